// File: doc/BRIEF.md
# Programmable Multi-Mode Interval Timer Channel

This block is one down-counting timer channel. It has a counting clock, a gate input and a single waveform output. A host first writes a control word. The control word picks one of six waveform modes and selects binary or decimal (BCD) counting. The host then writes a start count. Depending on the mode, the channel produces one of the following on its output:

- a level that rises at terminal count,
- a one-shot pulse started by the gate,
- a periodic one-clock low pulse,
- a square wave,
- a single one-clock strobe started by software or by the gate.

The gate either pauses counting or triggers it, depending on the mode. The host can freeze a snapshot of the running count and read it as bytes, low byte first, while counting goes on. A status byte reports the output level, whether a count is still missing, the mode and the number format.

The counter advances once per rising clock edge. The gate is sampled on the same clock. A start count of zero stands for the full range of the counter: 65536 in binary and 10000 in BCD at the default width.

Top module: `ivtimer_chan`

## Requirements
- R1: After reset the output is high, the status byte reads 0xC0 and the read port shows 0x00.
- R2: In mode 0, a count write of N drives the output low at that edge. The output rises N clock edges later and then stays high until the next write.
- R3: In modes 0, 2, 3 and 4, a clock edge with the gate low does not advance the count. Each such edge delays the next output event by one clock.
- R4: In mode 1, the output goes low at the edge that sees a gate rising edge and stays low for N clocks. A new gate rising edge during that time restarts the N-clock interval. Writing a count alone does not start it.
- R5: In mode 2, the output goes low for one clock every N clocks, first N edges after the write. While the gate is low the output is held high. A gate rising edge restarts the period from N.
- R6: In mode 3, the output is a square wave of period N that starts high. It is high for N/2 clocks and low for N/2 clocks when N is even. When N is odd it is high for (N+1)/2 clocks and low for (N-1)/2 clocks.
- R7: In mode 4, the output stays high except for a single one-clock low pulse N edges after the count write.
- R8: In mode 5, a count write alone leaves the output high. A gate rising edge starts the count, and the output pulses low for one clock N edges later. A further gate rising edge before terminal count restarts the count.
- R9: With the BCD bit set, the count steps through decimal values, for example 0x0012 becomes 0x0009 after three edges. The terminal timing follows the decimal value.
- R10: A start count of zero counts 10000 clocks in BCD and 65536 clocks in binary.
- R11: A latch command freezes the current count for reading; the count keeps running meanwhile. Further latch commands are ignored while a snapshot is pending. The read port shows the low byte first, and each read strobe advances to the next byte. After the high byte is read, the port returns to showing the live count's low byte.
- R12: The status byte has the output in bit 7 and the missing-count flag in bit 6. The flag is set by a control write and cleared by a count write. Bits 3:1 hold the mode, bit 0 holds the BCD flag and bits 5:4 are zero. Mode codes 6 and 7 act as, and read back as, modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_mode | input | 3 | Mode code written with the control word |
| ctrl_bcd | input | 1 | 1 selects BCD counting |
| cnt_we | input | 1 | Start count write strobe |
| cnt_val | input | 16 | Start count (binary or packed BCD) |
| gate_i | input | 1 | Gate, synchronous to clk |
| latch_i | input | 1 | Count snapshot command |
| rd_en | input | 1 | Advances the read byte pointer |
| rd_data | output | 8 | Selected byte of the snapshot or of the live count |
| stat_o | output | 8 | Status byte |
| out_o | output | 1 | Timer waveform output |

## Verification
The properties assume the following about the inputs:

- The gate is a clean signal synchronous to the clock.
- Mode 2 and 3 counts are at least 2.
- BCD counts hold only valid decimal digits.
- Control and count writes are single-cycle strobes.

The bench drives every input at the falling clock edge. It uses counts of 3 or more outside the zero-count cases, and BCD values with legal digits only. Under these conditions the output-level properties describe what a correct channel does. The bench never drives a combination outside them.

// File: rtl/ivtimer_pkg.sv
// Shared types for the interval timer channel.
// Assumes: mode codes 6 and 7 alias modes 2 and 3.
package ivtimer_pkg;

    typedef enum logic [2:0] {
        MD_TCOUNT  = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTROB = 3'd4,
        MD_HWSTROB = 3'd5
    } ivt_mode_e;

    // Fold the two alias codes onto their base modes.
    function automatic ivt_mode_e fold_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) begin
            return ivt_mode_e'({1'b0, code[1:0]});
        end
        return ivt_mode_e'(code);
    endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
// Gate rising-edge detector.
// Assumes: gate_i is already synchronous to clk.
module ivt_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_q;

    // Keep the previous gate level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_i;
        end
    end

    assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ivt_step.sv
// Count stepper: subtracts 1, 2 or 3 from the count in binary or BCD.
// Both formats wrap modulo their range.
// Assumes: in BCD mode every digit of cur is 0..9.
module ivt_step #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] cur,
    input  logic [1:0]   amt,
    input  logic         bcd,
    output logic [W-1:0] nxt
);
    logic signed [5:0] dig_diff;
    logic [1:0]        brw;

    // Digit-serial borrow chain for BCD, plain subtraction for binary.
    always_comb begin
        nxt      = cur - {{(W-2){1'b0}}, amt};
        brw      = amt;
        dig_diff = '0;
        if (bcd) begin
            for (int d = 0; d < DIGITS; d++) begin
                dig_diff = $signed({2'b00, cur[4*d +: 4]}) - $signed({4'b0000, brw});
                if (dig_diff < 0) begin
                    dig_diff = dig_diff + 6'sd10;
                    brw      = 2'd1;
                end else begin
                    brw      = 2'd0;
                end
                nxt[4*d +: 4] = dig_diff[3:0];
            end
        end
    end
endmodule

// File: rtl/ivt_readout.sv
// Count snapshot and byte-wise read port, low byte first.
// Assumes: W is a multiple of 8.
module ivt_readout #(
    parameter int W = 16,
    localparam int NBYTES = W / 8,
    localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         latch_i,
    input  logic         rd_en,
    input  logic [W-1:0] live,
    output logic [7:0]   rd_data
);
    logic [W-1:0] hold_q;
    logic         held_q;
    logic [PW-1:0] ptr_q;
    logic [W-1:0] src;

    // Capture on latch, step the byte pointer on each read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hold_q <= '0;
            held_q <= 1'b0;
            ptr_q  <= '0;
        end else begin
            if (latch_i && !held_q) begin
                hold_q <= live;
                held_q <= 1'b1;
            end
            if (rd_en) begin
                if (ptr_q == PW'(NBYTES - 1)) begin
                    ptr_q  <= '0;
                    held_q <= 1'b0;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    assign src     = held_q ? hold_q : live;
    assign rd_data = src[ptr_q*8 +: 8];
endmodule

// File: rtl/ivtimer_chan.sv
// One programmable interval timer channel with six waveform modes.
// Assumes: gate_i is synchronous to clk; counts are at least 2 in
// modes 2 and 3; BCD counts hold valid digits.
module ivtimer_chan
    import ivtimer_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic [2:0]   ctrl_mode,
    input  logic         ctrl_bcd,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_val,
    input  logic         gate_i,
    input  logic         latch_i,
    input  logic         rd_en,
    output logic [7:0]   rd_data,
    output logic [7:0]   stat_o,
    output logic         out_o
);
    ivt_mode_e    mode_q;
    logic         bcd_q;
    logic [W-1:0] reload_q;
    logic [W-1:0] count_q;
    logic         out_q;
    logic         run_q;
    logic         armed_q;
    logic         nocnt_q;
    logic         gate_rise;
    logic [1:0]   step_amt;
    logic [W-1:0] count_nxt;
    logic         at_term;
    ivt_mode_e    new_mode;

    ivt_gate_edge u_gedge (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_i),
        .rise_o (gate_rise)
    );

    ivt_step #(.DIGITS(DIGITS)) u_step (
        .cur (count_q),
        .amt (step_amt),
        .bcd (bcd_q),
        .nxt (count_nxt)
    );

    ivt_readout #(.W(W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctrl_we),
        .latch_i (latch_i),
        .rd_en   (rd_en),
        .live    (count_q),
        .rd_data (rd_data)
    );

    // Step size: square wave counts by two, with an odd start trimmed per phase.
    always_comb begin
        step_amt = 2'd1;
        if (mode_q == MD_SQUARE) begin
            if (count_q[0]) begin
                step_amt = out_q ? 2'd1 : 2'd3;
            end else begin
                step_amt = 2'd2;
            end
        end
    end

    assign at_term  = (count_q == {{(W-2){1'b0}}, step_amt});
    assign new_mode = fold_mode(ctrl_mode);

    // Mode sequencer: loads, steps and shapes the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MD_TCOUNT;
            bcd_q    <= 1'b0;
            reload_q <= '0;
            count_q  <= '0;
            out_q    <= 1'b1;
            run_q    <= 1'b0;
            armed_q  <= 1'b0;
            nocnt_q  <= 1'b1;
        end else if (ctrl_we) begin
            mode_q  <= new_mode;
            bcd_q   <= ctrl_bcd;
            out_q   <= (new_mode != MD_TCOUNT);
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            nocnt_q <= 1'b1;
        end else if (cnt_we) begin
            reload_q <= cnt_val;
            armed_q  <= 1'b1;
            nocnt_q  <= 1'b0;
            unique case (mode_q)
                MD_TCOUNT: begin
                    count_q <= cnt_val;
                    out_q   <= 1'b0;
                    run_q   <= 1'b1;
                end
                MD_RATE, MD_SQUARE, MD_SWSTROB: begin
                    count_q <= cnt_val;
                    out_q   <= 1'b1;
                    run_q   <= 1'b1;
                end
                default: begin
                    // Gate-triggered modes wait for the next gate edge.
                end
            endcase
        end else begin
            unique case (mode_q)
                MD_TCOUNT, MD_SWSTROB: begin
                    if (mode_q == MD_SWSTROB && !out_q) begin
                        out_q <= 1'b1;
                    end
                    if (run_q && gate_i) begin
                        count_q <= count_nxt;
                        if (at_term) begin
                            run_q <= 1'b0;
                            out_q <= (mode_q == MD_TCOUNT);
                        end
                    end
                end
                MD_ONESHOT, MD_HWSTROB: begin
                    if (gate_rise && armed_q) begin
                        count_q <= reload_q;
                        run_q   <= 1'b1;
                        out_q   <= (mode_q == MD_HWSTROB);
                    end else if (run_q) begin
                        count_q <= count_nxt;
                        if (at_term) begin
                            run_q <= 1'b0;
                            out_q <= (mode_q == MD_ONESHOT);
                        end
                    end else if (mode_q == MD_HWSTROB && !out_q) begin
                        out_q <= 1'b1;
                    end
                end
                default: begin
                    if (gate_rise && armed_q) begin
                        count_q <= reload_q;
                        run_q   <= 1'b1;
                        out_q   <= 1'b1;
                    end else if (!gate_i) begin
                        out_q <= 1'b1;
                    end else if (run_q) begin
                        if (at_term) begin
                            count_q <= reload_q;
                            out_q   <= (mode_q == MD_RATE) ? 1'b0 : ~out_q;
                        end else begin
                            count_q <= count_nxt;
                            if (mode_q == MD_RATE) begin
                                out_q <= 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign out_o  = out_q;
    assign stat_o = {out_q, nocnt_q, 2'b00, mode_q, bcd_q};
endmodule

// File: rtl/ivtimer_chan_chk.sv
// Port-level properties of the timer channel, attached by bind.
// Assumes: the inputs meet the limits stated in the brief.
module ivtimer_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [2:0] ctrl_mode,
    input logic       ctrl_bcd,
    input logic       cnt_we,
    input logic       gate_i,
    input logic [7:0] stat_o,
    input logic       out_o
);
    // R2
    tcount_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[3:1] == 3'd0 && $fell(out_o)) |-> $past(cnt_we || ctrl_we));

    // R5
    rate_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[3:1] == 3'd2 && !gate_i && !ctrl_we) |=> out_o);

    // R7
    sw_strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[3:1] == 3'd4 && !out_o && !ctrl_we) |=> out_o);

    // R8
    hw_strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[3:1] == 3'd5 && !out_o && !ctrl_we) |=> out_o);

    // R12
    count_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !ctrl_we) |=> !stat_o[6]);

    // R12
    ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_mode < 3'd6) |=>
            (stat_o[3:1] == $past(ctrl_mode) && stat_o[0] == $past(ctrl_bcd) && stat_o[6]));
endmodule

bind ivtimer_chan ivtimer_chan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ctrl_mode (ctrl_mode),
    .ctrl_bcd  (ctrl_bcd),
    .cnt_we    (cnt_we),
    .gate_i    (gate_i),
    .stat_o    (stat_o),
    .out_o     (out_o)
);

// File: tb/ivtimer_chan_bench.sv
// Directed bench for the timer channel: one task per scenario.
module ivtimer_chan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_mode = 3'd0;
    logic        ctrl_bcd = 1'b0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_val = 16'd0;
    logic        gate_i = 1'b1;
    logic        latch_i = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [7:0]  stat_o;
    logic        out_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    ivtimer_chan u_ivtimer_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_mode (ctrl_mode),
        .ctrl_bcd  (ctrl_bcd),
        .cnt_we    (cnt_we),
        .cnt_val   (cnt_val),
        .gate_i    (gate_i),
        .latch_i   (latch_i),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .stat_o    (stat_o),
        .out_o     (out_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WDOG_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [2:0] m, input logic b);
        ctrl_mode = m; ctrl_bcd = b; ctrl_we = 1'b1;
        tick(1);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        cnt_val = v; cnt_we = 1'b1;
        tick(1);
        cnt_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 out", int'(out_o), 1);
        check("R1 status", int'(stat_o), 8'hC0);
        check("R1 read", int'(rd_data), 0);
    endtask

    task automatic t_mode0();
        gate_i = 1'b1;
        wr_ctrl(3'd0, 1'b0);
        check("R12 status mode0", int'(stat_o), 8'h40);
        wr_cnt(16'd5);
        check("R2 low at write", int'(out_o), 0);
        tick(4);
        check("R2 low before N", int'(out_o), 0);
        tick(1);
        check("R2 high at N", int'(out_o), 1);
        tick(3);
        check("R2 stays high", int'(out_o), 1);
        // R3: two gate-low edges delay the rise by two clocks
        wr_cnt(16'd4);
        tick(1);
        gate_i = 1'b0;
        tick(2);
        gate_i = 1'b1;
        tick(2);
        check("R3 suspended", int'(out_o), 0);
        tick(1);
        check("R3 delayed rise", int'(out_o), 1);
    endtask

    task automatic t_mode1();
        gate_i = 1'b0;
        wr_ctrl(3'd1, 1'b0);
        wr_cnt(16'd4);
        check("R4 no trigger on write", int'(out_o), 1);
        tick(3);
        check("R4 idle without gate", int'(out_o), 1);
        gate_i = 1'b1;
        tick(1);
        check("R4 low on trigger", int'(out_o), 0);
        tick(3);
        check("R4 low through N", int'(out_o), 0);
        tick(1);
        check("R4 high after N", int'(out_o), 1);
        gate_i = 1'b0; tick(1);
        gate_i = 1'b1; tick(1);
        gate_i = 1'b0; tick(1);
        gate_i = 1'b1; tick(1);
        tick(3);
        check("R4 retrigger extends", int'(out_o), 0);
        tick(1);
        check("R4 retrigger end", int'(out_o), 1);
    endtask

    task automatic t_mode2();
        gate_i = 1'b1;
        wr_ctrl(3'd2, 1'b0);
        wr_cnt(16'd4);
        for (int i = 0; i < 10; i++) begin
            check("R5 rate pattern", int'(out_o), int'((i == 0) || (i % 4 != 0)));
            tick(1);
        end
        gate_i = 1'b0;
        tick(1);
        check("R5 gate low forces high", int'(out_o), 1);
        tick(4);
        check("R5 held high", int'(out_o), 1);
        gate_i = 1'b1;
        tick(4);
        check("R5 restart high", int'(out_o), 1);
        tick(1);
        check("R5 restart pulse", int'(out_o), 0);
    endtask

    task automatic t_mode3();
        gate_i = 1'b1;
        wr_ctrl(3'd3, 1'b0);
        wr_cnt(16'd5);
        for (int i = 0; i < 12; i++) begin
            check("R6 odd square", int'(out_o), int'((i % 5) < 3));
            tick(1);
        end
        wr_cnt(16'd4);
        for (int i = 0; i < 10; i++) begin
            check("R6 even square", int'(out_o), int'((i % 4) < 2));
            tick(1);
        end
    endtask

    task automatic t_mode4();
        gate_i = 1'b1;
        wr_ctrl(3'd4, 1'b0);
        wr_cnt(16'd3);
        for (int i = 0; i < 8; i++) begin
            check("R7 sw strobe", int'(out_o), int'(i != 3));
            tick(1);
        end
    endtask

    task automatic t_mode5();
        gate_i = 1'b0;
        wr_ctrl(3'd5, 1'b0);
        wr_cnt(16'd3);
        tick(2);
        check("R8 no start on write", int'(out_o), 1);
        gate_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            check("R8 hw strobe", int'(out_o), int'(i != 3));
        end
        gate_i = 1'b0; tick(1);
        gate_i = 1'b1; tick(1);
        gate_i = 1'b0; tick(1);
        gate_i = 1'b1; tick(1);
        tick(2);
        check("R8 retrigger delays", int'(out_o), 1);
        tick(1);
        check("R8 retrigger strobe", int'(out_o), 0);
        tick(1);
        check("R8 strobe ends", int'(out_o), 1);
    endtask

    task automatic t_bcd();
        gate_i = 1'b1;
        wr_ctrl(3'd0, 1'b1);
        wr_cnt(16'h0012);
        tick(3);
        check("R9 decimal step", int'(rd_data), 8'h09);
        tick(8);
        check("R9 low before 12", int'(out_o), 0);
        tick(1);
        check("R9 rise at 12", int'(out_o), 1);
    endtask

    task automatic t_zero();
        gate_i = 1'b1;
        wr_ctrl(3'd0, 1'b1);
        wr_cnt(16'h0000);
        tick(9999);
        check("R10 bcd zero low", int'(out_o), 0);
        tick(1);
        check("R10 bcd zero 10000", int'(out_o), 1);
        wr_ctrl(3'd0, 1'b0);
        wr_cnt(16'h0000);
        tick(65535);
        check("R10 bin zero low", int'(out_o), 0);
        tick(1);
        check("R10 bin zero 65536", int'(out_o), 1);
    endtask

    task automatic t_latch();
        gate_i = 1'b1;
        wr_ctrl(3'd2, 1'b0);
        wr_cnt(16'd100);
        tick(10);
        latch_i = 1'b1; tick(1); latch_i = 1'b0;
        check("R11 snapshot low", int'(rd_data), 90);
        tick(5);
        check("R11 snapshot frozen", int'(rd_data), 90);
        latch_i = 1'b1; tick(1); latch_i = 1'b0;
        check("R11 relatch ignored", int'(rd_data), 90);
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
        check("R11 snapshot high", int'(rd_data), 0);
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
        check("R11 live after read", int'(rd_data), 81);
    endtask

    task automatic t_status();
        gate_i = 1'b1;
        wr_ctrl(3'd7, 1'b0);
        check("R12 alias 7 readback", int'(stat_o), 8'hC6);
        wr_cnt(16'd4);
        check("R12 count clears flag", int'(stat_o), 8'h86);
        wr_ctrl(3'd5, 1'b1);
        check("R12 mode5 bcd", int'(stat_o), 8'hCB);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        t_bcd();
        t_latch();
        t_status();
        t_zero();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule